// File: doc/BRIEF.md
# Three-Input Logic State Trigger

This block watches three one-bit digitized signals: two channel comparator outputs and the external trigger input. It forms one selectable Boolean function of them: AND, OR, exclusive-OR or two-of-three majority. It emits a one-cycle trigger pulse when that function moves into a chosen state, either going true or going false. Each input can be inverted so that "true" means low. Each input can also be left out of the function. A separate qualifying clock signal decides when a change counts. In edge mode the function is sampled on a chosen edge of the qualifying clock and compared with the previous sample. In level mode any change of the function counts, but only while the qualifying clock sits at a chosen level.

All three data inputs and the qualifying clock are asynchronous to the system clock. Each passes through a two-stage synchronizer before evaluation. After one trigger the block disarms itself. The `arm` input must be pulsed before another trigger can occur. This lets sweep control take one event at a time.

Top module: `logic_state_trigger`

## Requirements
- R1: After reset, `trig` and `armed` are 0. `armed` stays 0 until `arm` is pulsed.
- R2: With `cfg_func` = 2'b00 (AND), the function is true when every enabled input is true.
- R3: With `cfg_func` = 2'b01 (OR), the function is true when any enabled input is true.
- R4: With `cfg_func` = 2'b10 (XOR), the function is the parity of the enabled inputs. A change on an input whose `cfg_en` bit is 0 causes no trigger.
- R5: With `cfg_func` = 2'b11 (majority), the function is true when at least two enabled inputs are true.
- R6: Input i is true when `din[i]` differs from `cfg_pol[i]`. Bit i = 1 means the input is active low.
- R7: A trigger requires the function to change into the state given by `cfg_target` (1 = going true, 0 = going false). A change away from that state never triggers.
- R8: With `cfg_mode` = 1 (level), a function change triggers only while the synchronized `qclk` equals `cfg_qlevel`.
- R9: With `cfg_mode` = 0 (edge), the function is sampled only on a `qclk` edge that ends at `cfg_qlevel` (1 = rising, 0 = falling). A trigger occurs when the new sample equals the target and differs from the previous sample. A function change between edges alone does not trigger.
- R10: `trig` is high for exactly one cycle and only while `armed` is 1. A trigger clears `armed`, and a later pulse on `arm` sets it again.
- R11: A disabled input (`cfg_en[i]` = 0) counts as true for AND and as false for OR, XOR and majority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 3 | Asynchronous inputs: bit 0 and bit 1 are the channel comparators, bit 2 is the external trigger input |
| qclk | input | 1 | Asynchronous qualifying clock |
| cfg_func | input | 2 | Function: 00 AND, 01 OR, 10 XOR, 11 majority |
| cfg_pol | input | 3 | Per-input inversion (1 = active low) |
| cfg_en | input | 3 | Per-input enable |
| cfg_target | input | 1 | Target state: 1 = going true, 0 = going false |
| cfg_mode | input | 1 | 0 = edge qualified, 1 = level qualified |
| cfg_qlevel | input | 1 | Qualifying edge direction (edge mode) or qualifying level (level mode) |
| arm | input | 1 | Single-cycle pulse that arms the trigger |
| trig | output | 1 | Single-cycle trigger pulse |
| armed | output | 1 | The trigger is armed |

## Verification
The hardest case to reach is edge mode, where the trigger depends on two samples taken at separate qualifying edges. A function change that happens between edges must stay silent until the next qualifying edge. The bench builds this case step by step. It presents the starting pattern, applies a qualifying edge to store the first sample, and returns the qualifying clock through a non-qualifying edge. It then re-arms, applies the new pattern and counts pulses twice: once before the next qualifying edge, where none may appear, and once after it. Random trials repeat this with random function, polarity, enable, target and edge-direction settings, alongside the level-mode trials.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int NUM_IN = 3;

  typedef enum logic [1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_XOR = 2'b10,
    FN_MAJ = 2'b11
  } lst_func_e;
endpackage

// File: rtl/lst_sync.sv
module lst_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (g == 0) begin
          stage_q[g] <= d;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lst_func.sv
module lst_func
  import lst_pkg::*;
(
  input  lst_func_e         func,
  input  logic [NUM_IN-1:0] in_s,
  input  logic [NUM_IN-1:0] pol,
  input  logic [NUM_IN-1:0] en,
  output logic              fval
);
  localparam int CNT_W = $clog2(NUM_IN + 1);

  logic [NUM_IN-1:0] term;
  logic [CNT_W-1:0]  ones;

  genvar i;
  generate
    for (i = 0; i < NUM_IN; i++) begin : g_term
      always_comb begin
        if (en[i]) term[i] = in_s[i] ^ pol[i];
        else       term[i] = (func == FN_AND);
      end
    end
  endgenerate

  always_comb begin
    ones = '0;
    for (int k = 0; k < NUM_IN; k++) ones = ones + CNT_W'(term[k]);
  end

  always_comb begin
    unique case (func)
      FN_AND:  fval = &term;
      FN_OR:   fval = |term;
      FN_XOR:  fval = ^term;
      default: fval = (ones >= CNT_W'(2));
    endcase
  end
endmodule

// File: rtl/lst_eval.sv
module lst_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic fval,
  input  logic q_s,
  input  logic mode_lvl,
  input  logic qlevel,
  input  logic target,
  input  logic arm,
  output logic trig,
  output logic armed
);
  logic q_d, q_d_n;
  logic f_prev, f_prev_n, prev_vld, prev_vld_n;
  logic smp, smp_n, smp_vld, smp_vld_n;
  logic trig_q, trig_n, armed_q, armed_n;
  logic q_edge, fire_lvl, fire_edg, fire;

  always_comb begin
    q_edge   = (q_s != q_d) && (q_s == qlevel);
    fire_lvl = prev_vld && (fval != f_prev) && (fval == target) && (q_s == qlevel);
    fire_edg = q_edge && smp_vld && (fval != smp) && (fval == target);
    fire     = armed_q && (mode_lvl ? fire_lvl : fire_edg);

    q_d_n      = q_s;
    f_prev_n   = fval;
    prev_vld_n = 1'b1;
    smp_n      = q_edge ? fval : smp;
    smp_vld_n  = smp_vld | q_edge;
    trig_n     = fire;
    if (arm)       armed_n = 1'b1;
    else if (fire) armed_n = 1'b0;
    else           armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d      <= 1'b0;
      f_prev   <= 1'b0;
      prev_vld <= 1'b0;
      smp      <= 1'b0;
      smp_vld  <= 1'b0;
      trig_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      q_d      <= q_d_n;
      f_prev   <= f_prev_n;
      prev_vld <= prev_vld_n;
      smp      <= smp_n;
      smp_vld  <= smp_vld_n;
      trig_q   <= trig_n;
      armed_q  <= armed_n;
    end
  end

  assign trig  = trig_q;
  assign armed = armed_q;
endmodule

// File: rtl/logic_state_trigger.sv
module logic_state_trigger
  import lst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] din,
  input  logic              qclk,
  input  logic [1:0]        cfg_func,
  input  logic [NUM_IN-1:0] cfg_pol,
  input  logic [NUM_IN-1:0] cfg_en,
  input  logic              cfg_target,
  input  logic              cfg_mode,
  input  logic              cfg_qlevel,
  input  logic              arm,
  output logic              trig,
  output logic              armed
);
  localparam int SW = NUM_IN + 1;

  logic [SW-1:0]     sync_q;
  logic [NUM_IN-1:0] in_s;
  logic              q_s;
  logic              fval;

  lst_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({qclk, din}), .q(sync_q)
  );

  assign in_s = sync_q[NUM_IN-1:0];
  assign q_s  = sync_q[NUM_IN];

  lst_func u_func (
    .func(lst_func_e'(cfg_func)), .in_s(in_s), .pol(cfg_pol), .en(cfg_en), .fval(fval)
  );

  lst_eval u_eval (
    .clk(clk), .rst_n(rst_n), .fval(fval), .q_s(q_s), .mode_lvl(cfg_mode),
    .qlevel(cfg_qlevel), .target(cfg_target), .arm(arm), .trig(trig), .armed(armed)
  );
endmodule

// File: rtl/lst_checker.sv
module lst_checker (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic trig,
  input logic armed,
  input logic mode,
  input logic qlevel,
  input logic target,
  input logic q_s,
  input logic fval
);
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));

  p_arm_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(arm));

  p_hits_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(fval == target));

  p_level_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode)) |-> $past(q_s == qlevel));

  p_edge_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !$past(mode)) |-> $past(q_s == qlevel));
endmodule

bind logic_state_trigger lst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .armed(armed),
  .mode(cfg_mode), .qlevel(cfg_qlevel), .target(cfg_target),
  .q_s(q_s), .fval(fval)
);

// File: tb/tb_logic_state_trigger.sv
module tb_logic_state_trigger;
  logic       clk, rst_n, qclk, cfg_target, cfg_mode, cfg_qlevel, arm;
  logic [2:0] din, cfg_pol, cfg_en;
  logic [1:0] cfg_func;
  logic       trig, armed;
  int errors = 0, checks = 0;
  bit done = 0;

  logic_state_trigger dut (
    .clk(clk), .rst_n(rst_n), .din(din), .qclk(qclk), .cfg_func(cfg_func),
    .cfg_pol(cfg_pol), .cfg_en(cfg_en), .cfg_target(cfg_target), .cfg_mode(cfg_mode),
    .cfg_qlevel(cfg_qlevel), .arm(arm), .trig(trig), .armed(armed)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic bit f_model(logic [1:0] fn, logic [2:0] pol, logic [2:0] en, logic [2:0] d);
    bit [2:0] t;
    int n = 0;
    for (int i = 0; i < 3; i++) begin
      t[i] = en[i] ? (d[i] ^ pol[i]) : (fn == 2'b00);
      n += t[i];
    end
    case (fn)
      2'b00:   return &t;
      2'b01:   return |t;
      2'b10:   return ^t;
      default: return n >= 2;
    endcase
  endfunction

  function automatic int exp_cnt(logic [2:0] a, logic [2:0] b);
    bit fa = f_model(cfg_func, cfg_pol, cfg_en, a);
    bit fb = f_model(cfg_func, cfg_pol, cfg_en, b);
    return (fa != fb && fb == cfg_target) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (trig) c++;
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic cfg(logic [1:0] fn, logic [2:0] pol, logic [2:0] en,
                     logic tgt, logic md, logic ql);
    @(negedge clk);
    cfg_func = fn; cfg_pol = pol; cfg_en = en;
    cfg_target = tgt; cfg_mode = md; cfg_qlevel = ql;
  endtask

  task automatic level_trial(logic [2:0] a, logic [2:0] b, logic qhold, output int c);
    @(negedge clk); qclk = qhold; din = a;
    settle(8);
    pulse_arm();
    @(negedge clk); din = b;
    count(8, c);
  endtask

  task automatic edge_trial(logic [2:0] a, logic [2:0] b, output int c0, output int c1);
    @(negedge clk); qclk = ~cfg_qlevel; din = a;
    settle(8);
    @(negedge clk); qclk = cfg_qlevel;
    settle(8);
    @(negedge clk); qclk = ~cfg_qlevel;
    settle(8);
    pulse_arm();
    @(negedge clk); din = b;
    count(8, c0);
    @(negedge clk); qclk = cfg_qlevel;
    count(8, c1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c, c0, c1;
    string tag;
    void'($urandom(32'h5eed1));
    rst_n = 0; din = 0; qclk = 0; arm = 0;
    cfg_func = 0; cfg_pol = 0; cfg_en = 3'b111; cfg_target = 1; cfg_mode = 1; cfg_qlevel = 1;
    settle(4);
    check("R1 trig after reset", trig, 0);
    check("R1 armed after reset", armed, 0);
    @(negedge clk); rst_n = 1;
    settle(6);
    check("R1 armed stays low", armed, 0);

    // R2/R8: AND going true while qclk at qualifying level
    cfg(2'b00, 3'b000, 3'b111, 1, 1, 1);
    level_trial(3'b011, 3'b111, 1, c);
    check("R2 AND going true", c, 1);
    check("R10 disarmed after trigger", armed, 0);
    // R10: no re-arm, transitions again
    @(negedge clk); din = 3'b000;
    settle(8);
    @(negedge clk); din = 3'b111;
    count(8, c);
    check("R10 no trigger without re-arm", c, 0);
    // R8: wrong qualifying level
    level_trial(3'b011, 3'b111, 0, c);
    check("R8 wrong level blocks", c, 0);
    // R7: going false
    cfg(2'b00, 3'b000, 3'b111, 0, 1, 1);
    level_trial(3'b111, 3'b101, 1, c);
    check("R7 AND going false", c, 1);
    level_trial(3'b101, 3'b111, 1, c);
    check("R7 going true ignored for false target", c, 0);
    // R6: polarity inversion
    cfg(2'b00, 3'b111, 3'b111, 1, 1, 1);
    level_trial(3'b111, 3'b000, 1, c);
    check("R6 active-low inputs", c, 1);
    // R4: XOR on two inputs, disabled input toggles
    cfg(2'b10, 3'b000, 3'b011, 1, 1, 1);
    level_trial(3'b000, 3'b100, 1, c);
    check("R4 disabled input ignored", c, 0);
    level_trial(3'b100, 3'b101, 1, c);
    check("R4 XOR enabled input", c, 1);
    // R11: AND with only input 0 enabled
    cfg(2'b00, 3'b000, 3'b001, 1, 1, 1);
    level_trial(3'b000, 3'b001, 1, c);
    check("R11 disabled inputs true for AND", c, 1);
    // R5: majority
    cfg(2'b11, 3'b000, 3'b111, 1, 1, 0);
    level_trial(3'b001, 3'b101, 0, c);
    check("R5 majority two of three", c, 1);
    // R3: OR
    cfg(2'b01, 3'b000, 3'b111, 1, 1, 1);
    level_trial(3'b000, 3'b010, 1, c);
    check("R3 OR one input", c, 1);
    // R9: falling-edge qualified
    cfg(2'b00, 3'b000, 3'b111, 1, 0, 0);
    edge_trial(3'b110, 3'b111, c0, c1);
    check("R9 no trigger between edges", c0, 0);
    check("R9 falling edge samples", c1, 1);
    cfg(2'b01, 3'b000, 3'b111, 1, 0, 1);
    edge_trial(3'b000, 3'b100, c0, c1);
    check("R9 no trigger between edges rising", c0, 0);
    check("R9 rising edge samples", c1, 1);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] a, b;
      a = 3'($urandom); b = 3'($urandom);
      cfg(2'($urandom), 3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      case (cfg_func)
        2'b00: tag = "R2 random AND";
        2'b01: tag = "R3 random OR";
        2'b10: tag = "R4 random XOR";
        default: tag = "R5 random MAJ";
      endcase
      if (cfg_mode) begin
        level_trial(a, b, cfg_qlevel, c);
        check({tag, " R8 level"}, c, exp_cnt(a, b));
      end else begin
        edge_trial(a, b, c0, c1);
        check({tag, " R9 before edge"}, c0, 0);
        check({tag, " R9 edge"}, c1, exp_cnt(a, b));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule